// File: doc/BRIEF.md
# Sample-Rate Timing Selector Divider

This block produces the timing strobes that pace a pair of sample-rate converter channels. One 32-bit selection word configures two channels at once. For each channel it names a timing source and a division ratio. The source is one of three reference clocks, one of two baud-rate generator outputs, or a word-select line from a serial audio interface. Every source reaches the block as a one-cycle event pulse in the system clock domain. For a clock source, the channel counts events and raises its strobe for one cycle each time the count reaches the selected ratio. For a word-select source, each rising edge of the line passes straight through as a strobe.

The ratio is not a plain divide value. A 5-bit index selects from a non-linear ladder that runs from 2 to 98304. Each clock source also has its own enable bit. A channel whose clock source is disabled holds its counter at zero. Once a channel is running, a new field takes effect only when the count wraps, so a period already in progress is never cut short or stretched.

Top module: `tsel_divider`

## Requirements
- R1: Channel 0 takes bits [15:0] of `sel_word_i` and channel 1 takes bits [31:16]. Within each 16-bit field, bits [10:8] hold the source code and bits [4:0] hold the ratio index. All other bits are ignored.
- R2: Source codes 0, 1 and 2 count events on `ref_tick_i[0]`, `[1]` and `[2]`. Codes 3 and 4 count events on `brg_tick_i[0]` and `[1]`. Events on inputs that are not selected have no effect.
- R3: Codes 6 and 7 select word-select line (code − 6). The strobe is high for one cycle after each clock edge that samples a rising edge on that line. There is no division, and no enable bit is needed. Code 5 produces no strobes.
- R4: Ratio indices 0 to 3 divide by 2, 4, 6 and 8. Indices 4 to 28 alternately multiply the previous ratio by 3/2 and then by 4/3, giving 12, 16, 24, 32 and so on. Index 27 divides by 32768 and index 28 divides by 49152.
- R5: Index 29 divides by 98304. The reserved indices 30 and 31 also divide by 98304.
- R6: Clock source s runs only while bit s+1 of `div_en_i` is 1. While that bit is clear, the channel's counter stays at zero and the channel emits no strobe. When the bit is set again, counting starts from zero.
- R7: In clock mode, the strobe is one cycle wide. It appears in the cycle after the edge that samples the ratio-th event since counting started or since the previous strobe.
- R8: While a channel runs, changes to its field are held off until the wrapping edge. The new field, including one written so that it is first sampled on that same edge, sets the next period. While a channel is idle, its field is reloaded on every edge. A channel is idle when its clock source is disabled, when it uses code 5, or when it is in word-select mode.
- R9: During and directly after reset, all strobes are low and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_word_i | input | REG_W (32) | Packed selection word for two channels |
| div_en_i | input | 6 | Per-source enable; bit s+1 enables clock source s |
| ref_tick_i | input | 3 | Event pulses of the three reference clocks |
| brg_tick_i | input | 2 | Event pulses of the two baud-rate generators |
| ws_i | input | NUM_WS (2) | Word-select lines |
| strobe_o | output | 2 | Timing strobe per channel |

## Verification
Two events can land on the same clock edge: the counter wrapping, and a new field value or an enable change arriving. The bench writes a new ratio so that the design first samples it on the very edge where the old period ends. It judges the outcome by the spacing of the strobes that follow. The old period must finish at its original length, and the new ratio must govern the next period from that point on. A second case writes a field in the middle of a period, and a third removes the enable after part of a count. In each case the scoreboard requires strobes exactly at the predicted cycles and nowhere else.

// File: rtl/tsel_pkg.sv
package tsel_pkg;
  localparam int SRC_W        = 3;
  localparam int IDX_W        = 5;
  localparam int FIELD_W      = 16;
  localparam int SRC_LSB      = 8;
  localparam int IDX_LSB      = 0;
  localparam int NUM_REF      = 3;
  localparam int NUM_BRG      = 2;
  localparam int NUM_CLK_SRC  = NUM_REF + NUM_BRG;
  localparam int EN_W         = NUM_CLK_SRC + 1;
  localparam int WS_CODE_BASE = 6;
  localparam int LADDER_TOP   = 28;
  localparam int MAX_RATIO    = 98304;
  localparam int CNT_W        = $clog2(MAX_RATIO + 1);

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic [IDX_W-1:0] idx;
  } tsel_cfg_t;

  // Pull the source code and ratio index out of one channel field.
  function automatic tsel_cfg_t tsel_decode(input logic [FIELD_W-1:0] f);
    tsel_cfg_t c;
    c.src = f[SRC_LSB +: SRC_W];
    c.idx = f[IDX_LSB +: IDX_W];
    return c;
  endfunction

  // Ratio ladder: 2,4,6,8, then pairs of 12*2^p and 16*2^p, top entries fixed.
  function automatic logic [CNT_W-1:0] tsel_ratio(input logic [IDX_W-1:0] idx);
    int k;
    int r;
    k = int'(idx);
    if (k < 4) r = 2 * (k + 1);
    else if (k > LADDER_TOP) r = MAX_RATIO;
    else if (((k - 4) % 2) == 1) r = 16 << ((k - 4) / 2);
    else r = 12 << ((k - 4) / 2);
    return CNT_W'(r);
  endfunction
endpackage

// File: rtl/tsel_src_mux.sv
module tsel_src_mux
  import tsel_pkg::*;
#(
  parameter int NUM_WS = 2
) (
  input  logic [SRC_W-1:0]       src_i,
  input  logic [NUM_CLK_SRC-1:0] clk_evt_i,
  input  logic [EN_W-1:0]        div_en_i,
  input  logic [NUM_WS-1:0]      ws_rise_i,
  output logic                   div_mode_o,
  output logic                   ws_mode_o,
  output logic                   src_en_o,
  output logic                   src_evt_o
);
  always_comb begin
    div_mode_o = 1'b0;
    ws_mode_o  = 1'b0;
    src_en_o   = 1'b0;
    src_evt_o  = 1'b0;
    for (int s = 0; s < NUM_CLK_SRC; s++) begin
      if (int'(src_i) == s) begin
        div_mode_o = 1'b1;
        src_en_o   = div_en_i[s+1];
        src_evt_o  = clk_evt_i[s];
      end
    end
    for (int n = 0; n < NUM_WS; n++) begin
      if (int'(src_i) == WS_CODE_BASE + n) begin
        ws_mode_o = 1'b1;
        src_evt_o = ws_rise_i[n];
      end
    end
  end
endmodule

// File: rtl/tsel_div_chan.sv
module tsel_div_chan
  import tsel_pkg::*;
#(
  parameter int NUM_WS = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [FIELD_W-1:0]     field_i,
  input  logic [NUM_CLK_SRC-1:0] clk_evt_i,
  input  logic [EN_W-1:0]        div_en_i,
  input  logic [NUM_WS-1:0]      ws_rise_i,
  output logic                   strobe_o
);
  tsel_cfg_t        act_q;
  tsel_cfg_t        fld_cfg;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] ratio_act;
  logic [CNT_W-1:0] term_cnt;
  logic             div_mode, ws_mode, src_en, src_evt;
  logic             run, wrap, load, strobe_q;
  logic             unused_field;

  assign fld_cfg      = tsel_decode(field_i);
  assign unused_field = ^{field_i[FIELD_W-1:SRC_LSB+SRC_W], field_i[SRC_LSB-1:IDX_LSB+IDX_W]};

  tsel_src_mux #(.NUM_WS(NUM_WS)) u_mux (
    .src_i      (act_q.src),
    .clk_evt_i  (clk_evt_i),
    .div_en_i   (div_en_i),
    .ws_rise_i  (ws_rise_i),
    .div_mode_o (div_mode),
    .ws_mode_o  (ws_mode),
    .src_en_o   (src_en),
    .src_evt_o  (src_evt)
  );

  assign ratio_act = tsel_ratio(act_q.idx);
  assign term_cnt  = ratio_act - CNT_W'(1);
  assign run       = div_mode & src_en;
  assign wrap      = run & src_evt & (cnt_q == term_cnt);
  assign load      = wrap | ~run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= '0;
      cnt_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      if (load) act_q <= fld_cfg;
      if (!run) cnt_q <= '0;
      else if (src_evt) cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
      strobe_q <= wrap | (ws_mode & src_evt);
    end
  end

  assign strobe_o = strobe_q;

  // R7: a strobe is always caused by an event of the previously active source
  a_r7_strobe_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |-> $past(src_evt));

  // R7: a clock-mode strobe leaves the counter restarted
  a_r7_strobe_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_q && $past(div_mode)) |-> (cnt_q == '0));

  // R7: the counter never reaches the active ratio
  a_r7_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < ratio_act);

  // R6: a disabled clock source never yields a strobe
  a_r6_disabled_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (div_mode && !src_en) |=> !strobe_q);

  // R8: the active field holds between wraps while running
  a_r8_hold_between_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(act_q));
endmodule

// File: rtl/tsel_divider.sv
module tsel_divider
  import tsel_pkg::*;
#(
  parameter int NUM_WS = 2,
  parameter int REG_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [REG_W-1:0]         sel_word_i,
  input  logic [EN_W-1:0]          div_en_i,
  input  logic [NUM_REF-1:0]       ref_tick_i,
  input  logic [NUM_BRG-1:0]       brg_tick_i,
  input  logic [NUM_WS-1:0]        ws_i,
  output logic [REG_W/FIELD_W-1:0] strobe_o
);
  localparam int NUM_CH = REG_W / FIELD_W;

  logic [NUM_WS-1:0]      ws_q;
  logic [NUM_WS-1:0]      ws_rise;
  logic [NUM_CLK_SRC-1:0] clk_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ws_q <= '0;
    else        ws_q <= ws_i;
  end

  assign ws_rise = ws_i & ~ws_q;
  assign clk_evt = {brg_tick_i, ref_tick_i};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    tsel_div_chan #(.NUM_WS(NUM_WS)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .field_i   (sel_word_i[ch*FIELD_W +: FIELD_W]),
      .clk_evt_i (clk_evt),
      .div_en_i  (div_en_i),
      .ws_rise_i (ws_rise),
      .strobe_o  (strobe_o[ch])
    );
  end
endmodule

// File: tb/sim_tsel_divider.sv
`timescale 1ns/1ps
module sim_tsel_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] sel_word = '0;
  logic [5:0]  div_en = '0;
  logic [2:0]  ref_tick = '0;
  logic [1:0]  brg_tick = '0;
  logic [1:0]  ws = '0;
  logic [1:0]  strobe;

  always #4 clk = ~clk;

  tsel_divider #(.NUM_WS(2), .REG_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_word_i(sel_word), .div_en_i(div_en),
    .ref_tick_i(ref_tick), .brg_tick_i(brg_tick), .ws_i(ws), .strobe_o(strobe)
  );

  typedef struct { int at; string req; } exp_t;
  exp_t  q0[$];
  exp_t  q1[$];
  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    mon_on = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R9";
  int    per[5];
  int    base[5];

  always @(posedge clk) cyc <= cyc + 1;

  // Event generator: high at posedges base+1+per*j
  always @(negedge clk) begin
    logic [4:0] t;
    #1;
    for (int s = 0; s < 5; s++)
      t[s] = (per[s] > 0) && (cyc >= base[s]) && (((cyc - base[s]) % per[s]) == 0);
    ref_tick = t[2:0];
    brg_tick = t[4:3];
  end

  function automatic int model_ratio(int idx);
    int r;
    if (idx < 4) return 2 * idx + 2;
    if (idx > 28) return 98304;
    r = 8;
    for (int i = 4; i <= idx; i++) r = (i % 2 == 0) ? (r * 3) / 2 : (r * 4) / 3;
    return r;
  endfunction

  function automatic logic [15:0] fld(int s, int i);
    return {5'b0, s[2:0], 3'b0, i[4:0]};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_at(int ch, int at, string req);
    exp_t e;
    e.at = at; e.req = req;
    if (ch == 0) q0.push_back(e); else q1.push_back(e);
  endtask

  task automatic expect_div(int ch, int start, int period, int ratio, int count, string req);
    for (int m = 1; m <= count; m++) expect_at(ch, start + 1 + period * (ratio * m - 1), req);
  endtask

  // Monitor: pop and compare each strobe against the scoreboard
  always @(negedge clk) begin
    exp_t e;
    if (mon_on && !done) begin
      if (strobe[0]) begin
        if (q0.size() == 0) check(1'b0, cur_req, "unexpected strobe ch0 at cycle", cyc, -1);
        else begin e = q0.pop_front(); check(e.at == cyc, e.req, "strobe ch0 cycle", cyc, e.at); end
      end
      if (strobe[1]) begin
        if (q1.size() == 0) check(1'b0, cur_req, "unexpected strobe ch1 at cycle", cyc, -1);
        else begin e = q1.pop_front(); check(e.at == cyc, e.req, "strobe ch1 cycle", cyc, e.at); end
      end
    end
  end

  task automatic goto(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic quiet();
    div_en = '0;
    ws = '0;
    for (int s = 0; s < 5; s++) per[s] = 0;
    goto(cyc + 4);
    check(q0.size() == 0, cur_req, "missing strobes ch0", q0.size(), 0);
    check(q1.size() == 0, cur_req, "missing strobes ch1", q1.size(), 0);
    q0.delete(); q1.delete();
  endtask

  task automatic start_src(int s, int p, int c);
    per[s] = p; base[s] = c;
  endtask

  always @(posedge clk) begin
    if (cyc >= 190000 && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL %s watchdog: actual %0d expected %0d", cur_req, cyc, 190000);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int c;
    for (int s = 0; s < 5; s++) begin per[s] = 0; base[s] = 0; end
    repeat (3) @(negedge clk);
    check(strobe == 2'b00, "R9", "strobes in reset", int'(strobe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(strobe == 2'b00, "R9", "strobes after reset", int'(strobe), 0);
    mon_on = 1'b1;

    // R1 R2 R4: both halves, ignored bits set, clock A and B
    cur_req = "R1";
    sel_word = {fld(1, 3) | 16'hF8E0, fld(0, 0) | 16'hF8E0};
    goto(cyc + 2); c = cyc;
    start_src(0, 1, c); start_src(1, 1, c); div_en = 6'b000110;
    expect_div(0, c, 1, model_ratio(0), 8, "R1 R2 R4");
    expect_div(1, c, 1, model_ratio(3), 2, "R1 R2 R4");
    goto(c + 16); quiet();

    // R2 R6: baud A sparse events; ch1 on clock A without its enable bit
    cur_req = "R6";
    sel_word = {fld(0, 0), fld(3, 4)};
    goto(cyc + 2); c = cyc;
    start_src(3, 3, c); start_src(0, 1, c); div_en = 6'b010000;
    expect_div(0, c, 3, model_ratio(4), 2, "R2 R6");
    goto(c + 72); quiet();

    // R2: baud B on ch1 and clock C on ch0
    cur_req = "R2";
    sel_word = {fld(4, 5), fld(2, 0)};
    goto(cyc + 2); c = cyc;
    start_src(4, 2, c); start_src(2, 1, c); div_en = 6'b101000;
    expect_div(1, c, 2, model_ratio(5), 2, "R2 R4");
    expect_div(0, c, 1, model_ratio(0), 32, "R2");
    goto(c + 64); quiet();

    // R3: word-select pass-through on both lines
    cur_req = "R3";
    sel_word = {fld(7, 0), fld(6, 3)};
    goto(cyc + 2);
    div_en = 6'b111110; start_src(0, 1, cyc);
    goto(cyc + 1); c = cyc;
    expect_at(0, c + 1, "R3"); expect_at(0, c + 5, "R3");
    expect_at(1, c + 2, "R3"); expect_at(1, c + 8, "R3");
    ws[0] = 1'b1;
    goto(c + 1); ws[1] = 1'b1;
    goto(c + 2); ws[0] = 1'b0;
    goto(c + 4); ws[0] = 1'b1;
    goto(c + 5); ws[1] = 1'b0;
    goto(c + 6); ws[0] = 1'b0;
    goto(c + 7); ws[1] = 1'b1;
    goto(c + 10); quiet();

    // R3: code 5 stays silent under every event
    sel_word = {fld(5, 9), fld(5, 0)};
    goto(cyc + 2); c = cyc;
    div_en = 6'b111110;
    for (int s = 0; s < 5; s++) start_src(s, 1, c);
    goto(c + 2); ws[0] = 1'b1;
    goto(c + 3); ws[1] = 1'b1;
    goto(c + 4); ws[0] = 1'b0;
    goto(c + 20); quiet();

    // R6: wrong enable bit, then enable, pause, restart from zero
    cur_req = "R6";
    sel_word = {fld(5, 0), fld(0, 1)};
    goto(cyc + 2); c = cyc;
    start_src(0, 1, c); div_en = 6'b000100;
    expect_at(0, c + 14, "R6"); expect_at(0, c + 18, "R6");
    expect_at(0, c + 28, "R6"); expect_at(0, c + 32, "R6");
    goto(c + 10); div_en = 6'b000010;
    goto(c + 20); div_en = 6'b000000;
    goto(c + 24); div_en = 6'b000010;
    goto(c + 33); quiet();

    // R8: write landing on the wrap edge, then a write in mid-period
    cur_req = "R8";
    sel_word = {fld(5, 0), fld(0, 1)};
    goto(cyc + 2); c = cyc;
    start_src(0, 1, c); div_en = 6'b000010;
    expect_at(0, c + 4, "R8");  expect_at(0, c + 8, "R8");
    expect_at(0, c + 10, "R8"); expect_at(0, c + 12, "R8");
    expect_at(0, c + 14, "R8"); expect_at(0, c + 16, "R8");
    expect_at(0, c + 22, "R8"); expect_at(0, c + 28, "R8");
    goto(c + 7);  sel_word[15:0] = fld(0, 0);
    goto(c + 15); sel_word[15:0] = fld(0, 2);
    goto(c + 29); quiet();

    // R4: top of the ladder
    cur_req = "R4";
    sel_word = {fld(1, 28), fld(0, 27)};
    goto(cyc + 2); c = cyc;
    start_src(0, 1, c); start_src(1, 1, c); div_en = 6'b000110;
    expect_div(0, c, 1, model_ratio(27), 1, "R4");
    expect_div(1, c, 1, model_ratio(28), 1, "R4");
    goto(c + 49152); quiet();

    // R5: maximum and reserved indices, both channels strobe together
    cur_req = "R5";
    sel_word = {fld(1, 31), fld(0, 29)};
    goto(cyc + 2); c = cyc;
    start_src(0, 1, c); start_src(1, 1, c); div_en = 6'b000110;
    expect_div(0, c, 1, model_ratio(29), 1, "R5");
    expect_div(1, c, 1, model_ratio(31), 1, "R5");
    goto(c + 98304); quiet();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule